// File: doc/BRIEF.md
# Sound Processor Control Register Slave

This block is the two-wire serial control port of a television sound processor. A host controller writes the processor's settings over a standard-mode I2C link. These settings are the separation trim, the test hook, the output routing and forced-mono selects, the two output mutes, and the tone, volume and balance levels. The block holds them in six byte registers and presents them as decoded fields. A read transfer returns one status byte. That byte carries the live stereo and bilingual detector flags and a flag showing that the block has come out of reset.

A write transfer carries the device address, then one sub-address byte, then any number of data bytes. The sub-address steps forward after each data byte, so a host can load the whole register set in one burst. The pad is open-drain. The block samples the SCL and SDA inputs with its own clock and only ever pulls SDA low through `sda_lo_o`. It does not stretch the clock.

Top module: `audio_ctl_i2c`

## Requirements
- R1: Address byte 84h is acknowledged and starts a write, and address byte 85h is acknowledged and starts a read. Any other address byte is left unacknowledged, and the block ignores the bus until the next START.
- R2: Only bits 3..0 of the sub-address byte choose the register. Bits 7..4 have no effect.
- R3: Register map, with bit positions in the data byte. Sub 0 holds test at bit 7 and separation trim at bits 6..0. Sub 1 holds external select at bit 5, forced mono at bit 4, select S1 at bit 3, select S0 at bit 2, TV-output enable at bit 1 and speaker-output enable at bit 0; bits 7..6 are ignored. Sub 2 holds bass at bits 4..0. Sub 3 holds treble at bits 4..0. Sub 4 holds volume at bits 7..0. Sub 5 holds balance at bits 5..0. An enable bit of 0 means that output is muted.
- R4: After each data byte is stored, the sub-address increments by one, so consecutive data bytes fill consecutive registers.
- R5: Reset gives volume 0 and both enables 0, so both outputs are muted. It also gives trim 34h, bass 10h, treble 10h, balance 20h, and 0 in test, external select, forced mono, S1 and S0.
- R6: The status byte is {PON, stereo, bilingual, 00000} from bit 7 down to bit 0. The two flags are taken at the moment the byte starts to shift out.
- R7: PON is 1 after reset. It becomes 0 once the status byte has been sent, so later status bytes show PON = 0.
- R8: Data bytes sent to sub-addresses 6..15 are acknowledged and change no register.
- R9: The block acknowledges every address, sub-address and data byte it accepts by driving SDA low during the ninth clock. In a read, an acknowledge from the master brings another status byte, and a not-acknowledge makes the block release the bus.
- R10: The SDA drive changes only while SCL is low.
- R11: A STOP ends the transfer. Bytes clocked after it without a new START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 20x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad |
| sda_lo_o | output | 1 | 1 pulls the SDA pad low |
| stereo_i | input | 1 | Live stereo detector flag |
| biling_i | input | 1 | Live bilingual detector flag |
| test_o | output | 1 | Test mode select |
| sep_att_o | output | 7 | Stereo separation trim |
| ext_sel_o | output | 1 | Speaker output takes the external input |
| fmono_o | output | 1 | Forced mono |
| sel1_o | output | 1 | Output routing select S1 |
| sel0_o | output | 1 | Output routing select S0 |
| tv_on_o | output | 1 | TV output enable (0 = muted) |
| ls_on_o | output | 1 | Speaker output enable (0 = muted) |
| bass_o | output | 5 | Bass level |
| treble_o | output | 5 | Treble level |
| vol_o | output | 8 | Volume level |
| bal_o | output | 6 | Balance |

## Verification
The bench goes after sub-address handling. A slave that decodes all eight sub-address bits would drop writes that carry high bits. One that fails to step the sub-address would pile every burst byte into one register. One that ignores the implemented range would write the last register from sub-addresses 6 to 15. The bench also checks that PON clears after the first status byte and not before. A wrong design would report PON = 1 forever, or would clear it without ever showing it. It then checks that a foreign address or bytes after a STOP draw no acknowledge and no write. A slave that stays active after a mismatch would corrupt its settings from traffic meant for another device. Random bursts from a seeded generator are compared against a register model kept in the bench.

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int NREG = 6,
  parameter int SUBW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_lo_o,
  input  logic       stereo_i,
  input  logic       biling_i,
  output logic       test_o,
  output logic [6:0] sep_att_o,
  output logic       ext_sel_o,
  output logic       fmono_o,
  output logic       sel1_o,
  output logic       sel0_o,
  output logic       tv_on_o,
  output logic       ls_on_o,
  output logic [4:0] bass_o,
  output logic [4:0] treble_o,
  output logic [7:0] vol_o,
  output logic [5:0] bal_o
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA, K_READ} kind_t;

  function automatic logic [7:0] wmask(int i);
    case (i)
      1, 5:    return 8'h3F;
      2, 3:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rval(int i);
    case (i)
      0:       return 8'h34;
      2, 3:    return 8'h10;
      5:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  logic [2:0] scl_s, sda_s;
  st_t        st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [SUBW-1:0] sub;
  logic       ackd, mack, pon;
  logic [7:0] r [NREG];

  wire scl_q = scl_s[1];
  wire scl_p = scl_s[2];
  wire sda_q = sda_s[1];
  wire sda_p = sda_s[2];
  wire rise  = scl_q & ~scl_p;
  wire fall  = ~scl_q & scl_p;
  wire start = scl_q & scl_p & sda_p & ~sda_q;
  wire stop  = scl_q & scl_p & ~sda_p & sda_q;
  wire [7:0] status = {pon, stereo_i, biling_i, 5'b0};

  assign sda_lo_o = (st == S_RACK && ackd) || (st == S_TX && !tx[7]);

  assign {test_o, sep_att_o} = r[0];
  assign {ext_sel_o, fmono_o, sel1_o, sel0_o, tv_on_o, ls_on_o} = r[1][5:0];
  assign bass_o   = r[2][4:0];
  assign treble_o = r[3][4:0];
  assign vol_o    = r[4];
  assign bal_o    = r[5][5:0];

  wire unused_bits = &{r[1][7:6], r[2][7:5], r[3][7:5], r[5][7:6], scl_s[0], sda_s[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kind <= K_ADDR;
      cnt  <= '0;
      sh   <= '0;
      tx   <= '1;
      sub  <= '0;
      ackd <= 1'b0;
      mack <= 1'b0;
      pon  <= 1'b1;
      for (int i = 0; i < NREG; i++) r[i] <= rval(i);
    end else if (start) begin
      st   <= S_RX;
      kind <= K_ADDR;
      cnt  <= '0;
      ackd <= 1'b0;
    end else if (stop) begin
      st   <= S_IDLE;
      ackd <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (rise) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            st   <= S_RACK;
            ackd <= 1'b1;
            cnt  <= '0;
            case (kind)
              K_ADDR: begin
                if (sh[7:1] == DEV_ADDR) kind <= sh[0] ? K_READ : K_SUB;
                else begin
                  st   <= S_IDLE;
                  ackd <= 1'b0;
                end
              end
              K_SUB: begin
                sub  <= sh[SUBW-1:0];
                kind <= K_DATA;
              end
              default: begin
                for (int i = 0; i < NREG; i++)
                  if (sub == SUBW'(i)) r[i] <= sh & wmask(i);
                sub <= sub + 1'b1;
              end
            endcase
          end
        end
        S_RACK: if (fall) begin
          ackd <= 1'b0;
          if (kind == K_READ) begin
            st  <= S_TX;
            tx  <= status;
            pon <= 1'b0;
          end else st <= S_RX;
        end
        S_TX: if (fall) begin
          tx  <= {tx[6:0], 1'b1};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            st  <= S_MACK;
            cnt <= '0;
          end
        end
        S_MACK: begin
          if (rise) mack <= ~sda_q;
          else if (fall) begin
            if (mack) begin
              st  <= S_TX;
              tx  <= status;
              pon <= 1'b0;
            end else st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_lo_o,
  input logic [37:0] ctl
);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_lo_o) |-> !scl_i);

  assert_ctl_hold_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(ctl));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_values_R5: assert (ctl == {8'h34, 6'h00, 5'h10, 5'h10, 8'h00, 6'h20});
      assert_no_drive_reset_R9: assert (!sda_lo_o);
    end
  end

endmodule

bind audio_ctl_i2c audio_ctl_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_lo_o(sda_lo_o),
  .ctl({test_o, sep_att_o, ext_sel_o, fmono_o, sel1_o, sel0_o, tv_on_o, ls_on_o,
        bass_o, treble_o, vol_o, bal_o})
);

// File: tb/audio_ctl_i2c_tb.sv
module audio_ctl_i2c_tb;
  localparam int CLK_P = 10;
  localparam int Q = 10;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, stereo = 0, biling = 0;
  logic sda_lo;
  logic test, ext, fm, s1, s0, tvon, lson;
  logic [6:0] att;
  logic [4:0] bass, treb;
  logic [7:0] vol;
  logic [5:0] bal;
  wire sda_line = sda_m & ~sda_lo;
  int checks = 0, errors = 0, viol = 0;
  bit done = 0;
  logic [7:0] img [6];

  always #(CLK_P/2) clk = ~clk;

  audio_ctl_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_lo_o(sda_lo),
    .stereo_i(stereo), .biling_i(biling), .test_o(test), .sep_att_o(att),
    .ext_sel_o(ext), .fmono_o(fm), .sel1_o(s1), .sel0_o(s0), .tv_on_o(tvon),
    .ls_on_o(lson), .bass_o(bass), .treble_o(treb), .vol_o(vol), .bal_o(bal));

  wire [37:0] act = {test, att, ext, fm, s1, s0, tvon, lson, bass, treb, vol, bal};

  function automatic logic [37:0] expv();
    return {img[0], img[1][5:0], img[2][4:0], img[3][4:0], img[4], img[5][5:0]};
  endfunction

  function automatic logic [7:0] msk(int i);
    return (i == 1 || i == 5) ? 8'h3F : (i == 2 || i == 3) ? 8'h1F : 8'hFF;
  endfunction

  task automatic mdl_reset();
    img[0] = 8'h34; img[1] = 0; img[2] = 8'h10; img[3] = 8'h10; img[4] = 0; img[5] = 8'h20;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(act === expv(), req, 64'(act), 64'(expv()));
  endtask

  logic prev_scl = 1, prev_lo = 0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_lo !== prev_lo) viol++;
    prev_scl = scl_m;
    prev_lo = sda_lo;
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; wq(1); scl_m = 1; wq(1); sda_m = 0; wq(1); scl_m = 0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(1); scl_m = 1; wq(1); sda_m = 1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1);
    end
    sda_m = 1; wq(1); scl_m = 1; wq(1); ack = ~sda_line; wq(1); scl_m = 0; wq(1);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1; wq(1); b[i] = sda_line; wq(1); scl_m = 0;
    end
    wq(1); sda_m = ~mack; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1); sda_m = 1;
  endtask

  task automatic mdl_write(inout logic [3:0] sub, input logic [7:0] d);
    if (sub < 6) img[sub] = d & msk(int'(sub));
    sub = sub + 1;
  endtask

  initial begin
    repeat (20 * 200000 / 20) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [3:0] sub;
    void'($urandom(32'h5A17));
    mdl_reset();
    repeat (5) @(negedge clk);
    chk_regs("R5 reset values");
    chk(sda_lo === 0, "R9 no drive in reset", 64'(sda_lo), 0);
    rst_n = 1;
    wq(2);
    chk_regs("R5 after reset release");

    stereo = 1; biling = 0;
    i2c_start(); wbyte(8'h85, ack);
    chk(ack === 1, "R1 read address ack", 64'(ack), 1);
    rbyte(1, b);
    chk(b === 8'hC0, "R7 R6 first status with PON", 64'(b), 64'hC0);
    rbyte(0, b);
    chk(b === 8'h40, "R7 PON cleared on second byte", 64'(b), 64'h40);
    i2c_stop();
    stereo = 0; biling = 1;
    i2c_start(); wbyte(8'h85, ack); rbyte(0, b); i2c_stop();
    chk(b === 8'h20, "R6 bilingual status", 64'(b), 64'h20);

    i2c_start(); wbyte(8'h84, ack);
    chk(ack === 1, "R1 write address ack", 64'(ack), 1);
    wbyte(8'h00, ack);
    chk(ack === 1, "R9 sub-address ack", 64'(ack), 1);
    sub = 0;
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom) | 8'hC0;
      wbyte(b, ack);
      chk(ack === 1, "R9 data ack", 64'(ack), 1);
      mdl_write(sub, b);
    end
    i2c_stop();
    chk_regs("R4 R3 burst fills all registers");

    i2c_start(); wbyte(8'h84, ack); wbyte(8'hA4, ack); wbyte(8'h5C, ack); i2c_stop();
    sub = 4; mdl_write(sub, 8'h5C);
    chk_regs("R2 upper sub-address bits ignored");

    i2c_start(); wbyte(8'h84, ack); wbyte(8'h09, ack); wbyte(8'hE7, ack);
    chk(ack === 1, "R8 unimplemented sub ack", 64'(ack), 1);
    wbyte(8'h81, ack); i2c_stop();
    chk_regs("R8 unimplemented sub no change");

    i2c_start(); wbyte(8'h86, ack);
    chk(ack === 0, "R1 foreign address not acked", 64'(ack), 0);
    wbyte(8'h04, ack);
    chk(ack === 0, "R1 ignored after mismatch", 64'(ack), 0);
    wbyte(8'hFF, ack); i2c_stop();
    chk_regs("R1 no write after mismatch");

    wbyte(8'h84, ack);
    chk(ack === 0, "R11 no ack without START", 64'(ack), 0);
    wbyte(8'h04, ack); wbyte(8'hAA, ack); wq(2);
    chk_regs("R11 no write without START");

    for (int t = 0; t < 30; t++) begin
      logic [7:0] sb;
      int n;
      sb = 8'($urandom);
      n = 1 + int'($urandom % 3);
      sub = sb[3:0];
      i2c_start(); wbyte(8'h84, ack); wbyte(sb, ack);
      for (int k = 0; k < n; k++) begin
        b = 8'($urandom);
        wbyte(b, ack);
        chk(ack === 1, "R9 random data ack", 64'(ack), 1);
        mdl_write(sub, b);
      end
      i2c_stop();
      chk_regs("R4 R3 random burst");
    end

    stereo = 1; biling = 1;
    i2c_start(); wbyte(8'h85, ack); rbyte(0, b); i2c_stop();
    chk(b === 8'h60, "R7 PON stays clear", 64'(b), 64'h60);

    chk(viol == 0, "R10 drive changed while SCL high", 64'(viol), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule